// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block carries out a single raw NAND flash bus transaction each time software writes a control word whose start bit is set. One control word chooses which phases run: an opening command byte, column address bytes, row address bytes, a closing command byte, and a data transfer of one to four bytes. The phases always run in that order, and any phase that is not enabled is skipped. Once the last selected phase has finished, the engine clears the busy bit. Software polls that bit to learn that the transaction is done.

The host side is a small register port with six registers, selected by `reg_addr`: 0 control, 1 column address, 2 row address, 3 data, 4 strobe timing, 5 address configuration. Reads are combinational. The flash side drives CLE, ALE, active-low chip enable, write strobe and read strobe, and an 8-bit data bus split into output, output enable and input. It also samples the ready/busy line.

Each strobe phase lasts a programmable number of clock cycles, and all of these counts sit in one register. A bit in the control word keeps chip enable asserted after the transaction ends. Software uses it to chain several transactions into one long burst: it sets the bit on every word except the last.

Top module: `nand_seq_engine`

## Requirements
- R1: After reset, chip enable is high, both strobes are high and CLE and ALE are low. Control bit 31 reads 0 when idle. Writing a control word with bit 31 set starts a transaction, and bit 31 reads 1 until every selected phase is done. No strobe toggles while bit 31 is 0.
- R2: Control enable bits are: bit 16 opening command, bit 17 column, bit 18 row, bit 19 closing command, bit 20 read, bit 21 write. Enabled phases run in the order opening command, column, row, closing command, data. Disabled phases produce no bus cycle. A control word with no enable bits completes with no bus cycle.
- R3: A command cycle drives CLE high and pulses the write strobe. The opening command sends control bits 7:0 and the closing command sends bits 15:8.
- R4: An address cycle drives ALE high and pulses the write strobe, least significant byte first. The column phase sends (configuration bits 5:4)+1 bytes of the column register. The row phase sends (configuration bits 7:6)+1 bytes of the row register.
- R5: When control bit 24 is set, the column phase sends exactly one address byte of value 0x00, whatever the column register and configuration hold.
- R6: A write sends (control bits 29:28)+1 bytes of the data register, least significant byte first, each with ALE and CLE low.
- R7: A read pulses the read strobe (control bits 29:28)+1 times and samples the bus as the strobe rises. The bytes are placed least significant first into the data register, and its unfilled upper bytes become zero.
- R8: Chip enable is low for the whole transaction. At its end, chip enable goes high if control bit 30 is 0 and stays low if bit 30 is 1.
- R9: The timing register holds five 6-bit counts: bits 5:0 setup, 11:6 strobe low time, 17:12 hold after a write strobe, 23:18 hold after a read strobe, 29:24 long wait. Each count gives a phase length in clock cycles, and a count of 0 acts as 1.
- R10: After the closing command, the engine waits the long-wait count and then holds until ready/busy is high before any data cycle.
- R11: Control bit 26 reads the ready/busy input as it was one cycle earlier. Control bit 27 is set when a word requests both read and write. That word's data phase is then skipped. The bit is cleared by the next start.
- R12: While bit 31 reads 1, every register write is ignored, and the running transaction continues unchanged.
- R13: The write strobe and the read strobe are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data bus output |
| nf_dq_oe | output | 1 | Flash data bus output enable |
| nf_dq_i | input | 8 | Flash data bus input |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
Some properties are checked by assertions on every cycle: the strobes never overlap, CLE and ALE are exclusive, strobes occur only under chip enable and only while busy, registers stay frozen while busy, chip enable is released at the end of a transaction without the hold bit, and data never begins until ready has been seen. Other behaviour can only be shown by the bench's scenarios against a flash model: the exact byte sequence on the bus for each combination of phases, the address byte counts, the single zero byte of the special address, the width of each strobe pulse, the assembly of read bytes, the error flag, and the handling of a stalled ready line.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int REG_W          = 32;
    localparam int BYTE_W         = 8;
    localparam int WCNT_W         = 6;
    localparam int ADDR_BYTES_MAX = REG_W / BYTE_W;
    localparam int IDX_W          = $clog2(ADDR_BYTES_MAX);
    localparam int RA_W           = 3;

    // control word bit positions (software-visible)
    localparam int B_DO_CMD1 = 16;
    localparam int B_DO_COL  = 17;
    localparam int B_DO_ROW  = 18;
    localparam int B_DO_CMD2 = 19;
    localparam int B_RD      = 20;
    localparam int B_WR      = 21;
    localparam int B_SPEC    = 24;
    localparam int B_READY   = 26;
    localparam int B_ERR     = 27;
    localparam int B_LEN_LO  = 28;
    localparam int B_HOLD_CE = 30;
    localparam int B_GO      = 31;

    localparam logic [REG_W-1:0] STATUS_MASK =
        (32'h1 << B_GO) | (32'h1 << B_ERR) | (32'h1 << B_READY);

    localparam logic [RA_W-1:0] RA_CTL  = 3'd0;
    localparam logic [RA_W-1:0] RA_COL  = 3'd1;
    localparam logic [RA_W-1:0] RA_ROW  = 3'd2;
    localparam logic [RA_W-1:0] RA_DATA = 3'd3;
    localparam logic [RA_W-1:0] RA_WAIT = 3'd4;
    localparam logic [RA_W-1:0] RA_CFG  = 3'd5;

    typedef enum logic [1:0] {
        BK_CMD   = 2'd0,
        BK_ADDR  = 2'd1,
        BK_WDATA = 2'd2,
        BK_RDATA = 2'd3
    } bus_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_CMD1   = 4'd1,
        PH_COL    = 4'd2,
        PH_ROW    = 4'd3,
        PH_CMD2   = 4'd4,
        PH_LWAIT  = 4'd5,
        PH_RBWAIT = 4'd6,
        PH_DATA   = 4'd7,
        PH_END    = 4'd8
    } phase_e;

    typedef struct packed {
        logic [WCNT_W-1:0] lng;
        logic [WCNT_W-1:0] rd_hold;
        logic [WCNT_W-1:0] wr_hold;
        logic [WCNT_W-1:0] pulse;
        logic [WCNT_W-1:0] setup;
    } wait_cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0] row_m1;
        logic [IDX_W-1:0] col_m1;
    } addr_cfg_t;

    // a programmed count of zero behaves like one cycle
    function automatic logic [WCNT_W-1:0] cycles_m1(input logic [WCNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] w,
                                                   input logic [IDX_W-1:0] i);
        return w[{i, 3'b000} +: BYTE_W];
    endfunction

    // first enabled phase strictly after cur, in the fixed order
    function automatic phase_e next_phase(input phase_e cur, input logic [REG_W-1:0] c);
        phase_e n;
        n = PH_END;
        if (cur < PH_CMD1 && c[B_DO_CMD1])             n = PH_CMD1;
        else if (cur < PH_COL && c[B_DO_COL])          n = PH_COL;
        else if (cur < PH_ROW && c[B_DO_ROW])          n = PH_ROW;
        else if (cur < PH_CMD2 && c[B_DO_CMD2])        n = PH_CMD2;
        else if (cur < PH_DATA && (c[B_RD] || c[B_WR])) n = PH_DATA;
        return n;
    endfunction

endpackage

// File: rtl/nseq_regs.sv
module nseq_regs
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              ready,
    input  logic              err,
    input  logic              rd_load,
    input  logic [REG_W-1:0]  rd_word,
    output logic [REG_W-1:0]  rdata,
    output logic              start,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  col_q,
    output logic [REG_W-1:0]  row_q,
    output logic [REG_W-1:0]  data_q,
    output wait_cfg_t         wait_q,
    output addr_cfg_t         acfg
);

    localparam int CFG_W = 8;
    logic [CFG_W-1:0] cfg_q;
    logic             wr_ok;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (addr == RA_CTL) && wdata[B_GO];
    assign acfg  = addr_cfg_t'(cfg_q[7:4]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
            data_q <= '0;
            wait_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (addr)
                    RA_CTL:  ctl_q  <= wdata & ~STATUS_MASK;
                    RA_COL:  col_q  <= wdata;
                    RA_ROW:  row_q  <= wdata;
                    RA_DATA: data_q <= wdata;
                    RA_WAIT: wait_q <= wait_cfg_t'(wdata[$bits(wait_cfg_t)-1:0]);
                    RA_CFG:  cfg_q  <= wdata[CFG_W-1:0];
                    default: ;
                endcase
            end
            if (rd_load) data_q <= rd_word;
        end
    end

    always_comb begin
        case (addr)
            RA_CTL:  rdata = (ctl_q & ~STATUS_MASK)
                           | (REG_W'(busy)  << B_GO)
                           | (REG_W'(err)   << B_ERR)
                           | (REG_W'(ready) << B_READY);
            RA_COL:  rdata = col_q;
            RA_ROW:  rdata = row_q;
            RA_DATA: rdata = data_q;
            RA_WAIT: rdata = REG_W'(wait_q);
            RA_CFG:  rdata = REG_W'(cfg_q);
            default: rdata = '0;
        endcase
    end

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({ctl_q, col_q, row_q, wait_q, cfg_q})); // R12

endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_kind_e         kind,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [WCNT_W-1:0] t_setup,
    input  logic [WCNT_W-1:0] t_pulse,
    input  logic [WCNT_W-1:0] t_wr_hold,
    input  logic [WCNT_W-1:0] t_rd_hold,
    input  logic [BYTE_W-1:0] dq_i,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              done,
    output logic [BYTE_W-1:0] rd_byte
);

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD} st_e;

    st_e               st;
    bus_kind_e         kind_q;
    logic [BYTE_W-1:0] byte_q;
    logic [WCNT_W-1:0] cnt;
    logic              is_rd;
    logic              act;

    assign is_rd = (kind_q == BK_RDATA);
    assign act   = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind_q  <= BK_CMD;
            byte_q  <= '0;
            cnt     <= '0;
            done    <= 1'b0;
            rd_byte <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    kind_q <= kind;
                    byte_q <= byte_in;
                    cnt    <= cycles_m1(t_setup);
                    st     <= ST_SETUP;
                end
                ST_SETUP: if (cnt == '0) begin
                    cnt <= cycles_m1(t_pulse);
                    st  <= ST_PULSE;
                end else cnt <= cnt - 1'b1;
                ST_PULSE: if (cnt == '0) begin
                    if (is_rd) rd_byte <= dq_i;   // strobe rises at this edge
                    cnt <= is_rd ? cycles_m1(t_rd_hold) : cycles_m1(t_wr_hold);
                    st  <= ST_HOLD;
                end else cnt <= cnt - 1'b1;
                ST_HOLD: if (cnt == '0) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end else cnt <= cnt - 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cle   = act && (kind_q == BK_CMD);
    assign ale   = act && (kind_q == BK_ADDR);
    assign dq_oe = act && !is_rd;
    assign dq_o  = byte_q;
    assign we_n  = !((st == ST_PULSE) && !is_rd);
    assign re_n  = !((st == ST_PULSE) && is_rd);

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R13
    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale)); // R13
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == ST_IDLE)); // R2

endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  start_ctl,
    input  logic [REG_W-1:0]  ctl,
    input  logic [REG_W-1:0]  col,
    input  logic [REG_W-1:0]  row,
    input  logic [REG_W-1:0]  data,
    input  addr_cfg_t         acfg,
    input  logic [WCNT_W-1:0] t_long,
    input  logic              ready,
    input  logic              strb_done,
    input  logic [BYTE_W-1:0] strb_rd_byte,
    output logic              busy,
    output logic              err,
    output logic              ce_n,
    output logic              strb_start,
    output bus_kind_e         strb_kind,
    output logic [BYTE_W-1:0] strb_byte,
    output logic              rd_load,
    output logic [REG_W-1:0]  rd_word
);

    phase_e            ph;
    logic              pend;
    logic [IDX_W-1:0]  idx;
    logic [WCNT_W-1:0] lcnt;
    logic [REG_W-1:0]  word_q;
    logic              both;
    logic              is_rd;
    logic              bus_phase;
    logic [IDX_W-1:0]  data_last;

    assign both      = ctl[B_RD] && ctl[B_WR];
    assign is_rd     = ctl[B_RD];
    assign data_last = ctl[B_LEN_LO +: IDX_W];
    assign bus_phase = (ph == PH_CMD1) || (ph == PH_COL) || (ph == PH_ROW) ||
                       (ph == PH_CMD2) || ((ph == PH_DATA) && !both);
    assign strb_start = bus_phase && !pend;
    assign rd_load    = (ph == PH_END) && ctl[B_RD] && !ctl[B_WR];
    assign rd_word    = word_q;

    always_comb begin
        strb_kind = BK_CMD;
        strb_byte = '0;
        case (ph)
            PH_CMD1: strb_byte = ctl[7:0];
            PH_CMD2: strb_byte = ctl[15:8];
            PH_COL: begin
                strb_kind = BK_ADDR;
                strb_byte = ctl[B_SPEC] ? '0 : pick_byte(col, idx);
            end
            PH_ROW: begin
                strb_kind = BK_ADDR;
                strb_byte = pick_byte(row, idx);
            end
            PH_DATA: begin
                strb_kind = is_rd ? BK_RDATA : BK_WDATA;
                strb_byte = pick_byte(data, idx);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            pend   <= 1'b0;
            idx    <= '0;
            lcnt   <= '0;
            word_q <= '0;
            busy   <= 1'b0;
            err    <= 1'b0;
            ce_n   <= 1'b1;
        end else begin
            if (strb_start) pend <= 1'b1;
            case (ph)
                PH_IDLE: if (start) begin
                    busy   <= 1'b1;
                    err    <= 1'b0;
                    ce_n   <= 1'b0;
                    idx    <= '0;
                    word_q <= '0;
                    ph     <= next_phase(PH_IDLE, start_ctl);
                end
                PH_CMD1: if (strb_done) begin
                    pend <= 1'b0;
                    ph   <= next_phase(PH_CMD1, ctl);
                end
                PH_COL: if (strb_done) begin
                    pend <= 1'b0;
                    if (ctl[B_SPEC] || idx == acfg.col_m1) begin
                        idx <= '0;
                        ph  <= next_phase(PH_COL, ctl);
                    end else idx <= idx + 1'b1;
                end
                PH_ROW: if (strb_done) begin
                    pend <= 1'b0;
                    if (idx == acfg.row_m1) begin
                        idx <= '0;
                        ph  <= next_phase(PH_ROW, ctl);
                    end else idx <= idx + 1'b1;
                end
                PH_CMD2: if (strb_done) begin
                    pend <= 1'b0;
                    lcnt <= cycles_m1(t_long);
                    ph   <= PH_LWAIT;
                end
                PH_LWAIT: if (lcnt == '0) ph <= PH_RBWAIT;
                          else lcnt <= lcnt - 1'b1;
                PH_RBWAIT: if (ready) ph <= next_phase(PH_RBWAIT, ctl);
                PH_DATA: begin
                    if (both) begin
                        err <= 1'b1;
                        ph  <= PH_END;
                    end else if (strb_done) begin
                        pend <= 1'b0;
                        if (is_rd) word_q[{idx, 3'b000} +: BYTE_W] <= strb_rd_byte;
                        if (idx == data_last) begin
                            idx <= '0;
                            ph  <= PH_END;
                        end else idx <= idx + 1'b1;
                    end
                end
                PH_END: begin
                    busy <= 1'b0;
                    ce_n <= !ctl[B_HOLD_CE];
                    ph   <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_CE_HELD_IN_TXN: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE) |-> !ce_n); // R8
    AST_CE_FREED_AT_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !ctl[B_HOLD_CE]) |-> ce_n); // R8
    AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_DATA) && ($past(ph) == PH_RBWAIT)) |-> $past(ready)); // R10
    AST_ERR_ONLY_ON_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (ctl[B_RD] && ctl[B_WR])); // R11

endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [BYTE_W-1:0] nf_dq_o,
    output logic              nf_dq_oe,
    input  logic [BYTE_W-1:0] nf_dq_i,
    input  logic              nf_rb
);

    logic              ready_q;
    logic              busy, err, start, rd_load;
    logic [REG_W-1:0]  ctl_q, col_q, row_q, data_q, rd_word;
    wait_cfg_t         wait_q;
    addr_cfg_t         acfg;
    logic              strb_start, strb_done;
    bus_kind_e         strb_kind;
    logic [BYTE_W-1:0] strb_byte, strb_rd_byte;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= nf_rb;
    end

    nseq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy),
        .ready   (ready_q),
        .err     (err),
        .rd_load (rd_load),
        .rd_word (rd_word),
        .rdata   (reg_rdata),
        .start   (start),
        .ctl_q   (ctl_q),
        .col_q   (col_q),
        .row_q   (row_q),
        .data_q  (data_q),
        .wait_q  (wait_q),
        .acfg    (acfg)
    );

    nseq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_ctl    (reg_wdata),
        .ctl          (ctl_q),
        .col          (col_q),
        .row          (row_q),
        .data         (data_q),
        .acfg         (acfg),
        .t_long       (wait_q.lng),
        .ready        (ready_q),
        .strb_done    (strb_done),
        .strb_rd_byte (strb_rd_byte),
        .busy         (busy),
        .err          (err),
        .ce_n         (nf_ce_n),
        .strb_start   (strb_start),
        .strb_kind    (strb_kind),
        .strb_byte    (strb_byte),
        .rd_load      (rd_load),
        .rd_word      (rd_word)
    );

    nseq_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .start     (strb_start),
        .kind      (strb_kind),
        .byte_in   (strb_byte),
        .t_setup   (wait_q.setup),
        .t_pulse   (wait_q.pulse),
        .t_wr_hold (wait_q.wr_hold),
        .t_rd_hold (wait_q.rd_hold),
        .dq_i      (nf_dq_i),
        .cle       (nf_cle),
        .ale       (nf_ale),
        .we_n      (nf_we_n),
        .re_n      (nf_re_n),
        .dq_o      (nf_dq_o),
        .dq_oe     (nf_dq_oe),
        .done      (strb_done),
        .rd_byte   (strb_rd_byte)
    );

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nf_we_n && nf_re_n)); // R1
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R8

endmodule

// File: tb/tb_nand_seq_engine.sv
module tb_nand_seq_engine;

    localparam logic [31:0] GO   = 32'h8000_0000;
    localparam logic [31:0] HOLD = 32'h4000_0000;
    localparam logic [31:0] SPEC = 32'h0100_0000;
    localparam logic [31:0] C1   = 32'h0001_0000;
    localparam logic [31:0] CA   = 32'h0002_0000;
    localparam logic [31:0] RA   = 32'h0004_0000;
    localparam logic [31:0] C2   = 32'h0008_0000;
    localparam logic [31:0] RD   = 32'h0010_0000;
    localparam logic [31:0] WR   = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o;
    logic [7:0]  nf_dq_i = 8'h00;
    logic        nf_rb = 1'b1;

    always #10 clk = ~clk;

    nand_seq_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
        .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
    );

    typedef struct { int kind; logic [7:0] b; } ev_t;
    ev_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int exp_pw = 1;
    int re_falls = 0;
    logic [7:0] rd_mem [4];
    int rd_idx = 0;
    logic [31:0] sh_col, sh_row, sh_data, sh_cfg;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for write-strobe cycles and flash read model
    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_low = 0, re_low = 0;
    always @(negedge clk) begin
        if (!nf_we_n) we_low++;
        if (!nf_re_n) begin
            re_low++;
            nf_dq_i = rd_mem[rd_idx];
            if (prev_re) re_falls++;
        end
        if (nf_we_n && !prev_we) begin
            int kind;
            kind = nf_cle ? 0 : (nf_ale ? 1 : 2);
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected bus cycle", {24'h0, nf_dq_o}, 32'h0);
            end else begin
                ev_t e;
                string rq;
                e = exp_q.pop_front();
                rq = (e.kind == 0) ? "R3" : ((e.kind == 1) ? "R4" : "R6");
                chk(kind == e.kind, {rq, " cycle kind"}, kind, e.kind);
                chk(nf_dq_o == e.b, {rq, " bus byte"}, {24'h0, nf_dq_o}, {24'h0, e.b});
            end
            chk(we_low == exp_pw, "R9 write strobe width", we_low, exp_pw);
            we_low = 0;
        end
        if (nf_re_n && !prev_re) begin
            chk(re_low == exp_pw, "R9 read strobe width", re_low, exp_pw);
            re_low = 0;
            if (rd_idx < 3) rd_idx++;
        end
        prev_we = nf_we_n;
        prev_re = nf_re_n;
    end

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_expect(input logic [31:0] c);
        ev_t e;
        if (c[16]) begin e.kind = 0; e.b = c[7:0]; exp_q.push_back(e); end
        if (c[17]) begin
            if (c[24]) begin e.kind = 1; e.b = 8'h00; exp_q.push_back(e); end
            else for (int i = 0; i <= int'(sh_cfg[5:4]); i++) begin
                e.kind = 1; e.b = sh_col[8*i +: 8]; exp_q.push_back(e);
            end
        end
        if (c[18]) for (int i = 0; i <= int'(sh_cfg[7:6]); i++) begin
            e.kind = 1; e.b = sh_row[8*i +: 8]; exp_q.push_back(e);
        end
        if (c[19]) begin e.kind = 0; e.b = c[15:8]; exp_q.push_back(e); end
        if (c[21] && !c[20]) for (int i = 0; i <= int'(c[29:28]); i++) begin
            e.kind = 2; e.b = sh_data[8*i +: 8]; exp_q.push_back(e);
        end
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        bit idle = 0;
        for (int i = 0; i < 4000 && !idle; i++) begin
            host_rd(3'd0, v);
            if (!v[31]) idle = 1;
        end
        chk(idle, {req, " busy bit clears"}, {31'h0, idle}, 32'h1);
    endtask

    task automatic run(input logic [31:0] c, input string req);
        push_expect(c);
        host_wr(3'd0, c | GO);
        wait_idle(req);
        chk(exp_q.size() == 0, {req, " all expected bus cycles seen (R2)"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c;
        int re0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R1 reset pins",
            {27'h0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 32'h1C);
        host_rd(3'd0, v);
        chk((v & ~32'h0400_0000) == 0, "R1 control idle after reset", v, 32'h0);

        sh_cfg = (32'd2 << 6) | (32'd1 << 4);
        sh_col = 32'h0000_0234;
        sh_row = 32'h0001_2345;
        sh_data = 32'hA1B2_C3D4;
        host_wr(3'd5, sh_cfg);
        host_wr(3'd1, sh_col);
        host_wr(3'd2, sh_row);
        host_wr(3'd3, sh_data);

        // R3 R4 R6: program-style write, four bytes
        run(32'h80 | C1 | CA | RA | WR | (32'd3 << 28), "R6");
        chk(nf_ce_n == 1'b1, "R8 chip enable released", nf_ce_n, 1);

        // R2 empty control word
        run(32'h0, "R2");

        // R10 R11 R12: read blocked by busy flash
        rd_mem[0] = 8'h11; rd_mem[1] = 8'h22; rd_mem[2] = 8'h33; rd_mem[3] = 8'h44;
        rd_idx = 0;
        nf_rb = 1'b0;
        c = 32'h3000 | C1 | CA | RA | C2 | RD | (32'd3 << 28);
        push_expect(c);
        re0 = re_falls;
        host_wr(3'd0, c | GO);
        repeat (80) @(negedge clk);
        chk(re_falls == re0, "R10 no read before ready", re_falls, re0);
        host_rd(3'd0, v);
        chk(v[31] == 1'b1, "R1 busy while running", v[31], 1);
        chk(v[26] == 1'b0, "R11 ready bit low", v[26], 0);
        host_wr(3'd0, GO | 32'h00FF_00AA);
        host_wr(3'd1, 32'h0000_FFFF);
        nf_rb = 1'b1;
        wait_idle("R10");
        chk(exp_q.size() == 0, "R2 read sequence complete", exp_q.size(), 0);
        exp_q.delete();
        host_rd(3'd3, v);
        chk(v == 32'h4433_2211, "R7 read word", v, 32'h4433_2211);
        host_rd(3'd1, v);
        chk(v == sh_col, "R12 column kept", v, sh_col);
        host_rd(3'd0, v);
        chk(v[15:0] == 16'h3000, "R12 control kept", v[15:0], 32'h3000);
        chk(v[26] == 1'b1, "R11 ready bit high", v[26], 1);
        sh_data = 32'h4433_2211;

        // R5 special address, single-byte read
        rd_mem[0] = 8'hC2; rd_idx = 0;
        run(32'h90 | C1 | CA | SPEC | RD, "R5");
        host_rd(3'd3, v);
        chk(v == 32'h0000_00C2, "R7 one byte, upper zero", v, 32'hC2);
        sh_data = 32'hC2;

        // R8 hold chip enable
        run(32'h70 | C1 | HOLD, "R8");
        chk(nf_ce_n == 1'b0, "R8 chip enable held", nf_ce_n, 0);
        run(32'h70 | C1, "R8");
        chk(nf_ce_n == 1'b1, "R8 chip enable released after chain", nf_ce_n, 1);

        // R11 conflicting read and write
        re0 = re_falls;
        run(32'hFF | C1 | RD | WR, "R11");
        host_rd(3'd0, v);
        chk(v[27] == 1'b1, "R11 error bit set", v[27], 1);
        chk(re_falls == re0, "R11 no data cycles", re_falls, re0);
        run(32'h0, "R11");
        host_rd(3'd0, v);
        chk(v[27] == 1'b0, "R11 error cleared by next start", v[27], 0);

        // R9 programmed timing; R2 column skipped
        host_wr(3'd4, 32'd2 | (32'd3 << 6) | (32'd1 << 12) | (32'd2 << 18) | (32'd4 << 24));
        exp_pw = 3;
        sh_data = 32'h0000_BEEF;
        host_wr(3'd3, sh_data);
        run(32'h85 | C1 | RA | WR | (32'd1 << 28), "R9");
        rd_mem[0] = 8'h5A; rd_mem[1] = 8'hA5; rd_idx = 0;
        run(32'h3000 | C2 | RD | (32'd1 << 28), "R9");
        host_rd(3'd3, v);
        chk(v == 32'h0000_A55A, "R7 two-byte read", v, 32'hA55A);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule